// File: doc/BRIEF.md
# Auto-Increment Host Address Decoder

This block turns a host microcontroller's simple strobe bus into selects for the register units and data buffers of a larger chip. The host first performs an address-load, which places a 16-bit value into an internal address counter. Every following read or write strobe is carried out at the counter's present value, and the counter then moves on by one. A host can therefore stream through a run of consecutive registers or buffer words after giving a single start address.

The present address is split on its top nibble. A top nibble of zero means register space: the next nibble names a register unit and the low byte is the register offset inside that unit. Each unit has its own configurable register count. Top nibbles 1 to 3 and 8 to F each name one data buffer, and the low twelve bits are the word address inside it. Top nibbles 4 to 7 are unmapped. Any access at address 0x0000 raises a single-cycle pulse that clears the interrupt register elsewhere in the chip. This includes an access reached by counting through the wrap from 0xFFFF.

Decoding is combinational from the counter register, so selects, offsets and read data are valid in the same cycle as the host strobe. The counter advances at the clock edge that ends that cycle.

Top module: `autoinc_addr_dec`

## Requirements
- R1: An address-load cycle (`addrLoad` high) writes `hostWdata` into the counter. It is not an access: it raises no select, no `devRd`/`devWr`, no `intClr`, and no increment. The first access after it uses exactly the loaded address.
- R2: Each read or write access uses the current counter value and then adds one to it. With no load and no access, the counter holds its value.
- R3: Counting up from 0xFFFF gives 0x0000.
- R4: When address bits 15:12 equal 0, an access drives the one-hot `regSel` bit whose index equals bits 11:8, and `regOffset` equals bits 7:0.
- R5: When bits 15:12 are 1, 2 or 3, the access drives `bufSel` bit 0, 1 or 2. When they are 8 to F, it drives `bufSel` bits 3 to 10. `bufWord` equals bits 11:0.
- R6: When bits 15:12 are 4 to 7, the access drives no select, and `hostRdata` is zero.
- R7: A register-space access drives no select in two cases: the offset is at or above its unit's register count (defaults: unit 0 has 8, unit 1 has 64, unit 2 has 16, unit 3 has 256), or the unit number is at or above `NUM_UNITS` (default 4).
- R8: `intClr` is high exactly in the cycle of a read or write access at address 0x0000, including one reached by wrap-around.
- R9: During a read, `hostRdata` returns `regRdata` when a register is selected, returns `bufRdata` when a buffer is selected, and is zero otherwise. Outside reads it is zero.
- R10: If `addrLoad` is high in the same cycle as an access strobe, the load wins and the strobe is ignored. If read and write are both high, the cycle is a single write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the counter to 0x0000 |
| addrLoad | input | 1 | Address-load strobe |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 16 | Host data; the new address during a load |
| hostRdata | output | 16 | Read data returned to the host |
| regRdata | input | 16 | Read data from the selected register unit |
| bufRdata | input | 16 | Read data from the selected buffer |
| devRd | output | 1 | Read access in progress |
| devWr | output | 1 | Write access in progress |
| regSel | output | NUM_UNITS | One-hot register-unit select |
| regOffset | output | 8 | Register offset inside the unit |
| bufSel | output | 11 | One-hot buffer select |
| bufWord | output | 12 | Word address inside the buffer |
| intClr | output | 1 | Interrupt-register clear pulse |

## Verification
The decoder is driven with loaded start addresses in each kind of space: register units, every group of buffer codes, the unmapped nibbles, and the last legal and first illegal offset of a unit. This separates a correct space split from an off-by-one in the nibble-to-buffer mapping or in the per-unit bound. Runs of back-to-back reads and writes with no reload show that stepping happens exactly once per access, including across the 0xFFFF boundary. A load with no access before it at 0x0000, compared with an access reached there by counting, shows that the clear pulse follows accesses and not loads. Cycles with colliding strobes show the load and write priorities.

// File: rtl/autoinc_dec_pkg.sv
`timescale 1ns/1ps
package autoinc_dec_pkg;
  localparam int ADDR_W  = 16;
  localparam int SPACE_W = 4;
  localparam int UNIT_W  = 4;
  localparam int OFF_W   = ADDR_W - SPACE_W - UNIT_W;
  localparam int WORD_W  = ADDR_W - SPACE_W;
  localparam int NUM_BUFS = 11;

  typedef struct packed {
    logic loadCnt;
    logic stepCnt;
    logic accRd;
    logic accWr;
  } ctrlStrobe_t;

  // space code owned by buffer slot i: slots 0..2 -> 1..3, slots 3..10 -> 8..F
  function automatic logic [SPACE_W-1:0] slotSpace(input int i);
    if (i < 3) return SPACE_W'(i + 1);
    else       return SPACE_W'(i + 5);
  endfunction
endpackage

// File: rtl/autoinc_ctrl.sv
`timescale 1ns/1ps
module autoinc_ctrl
  import autoinc_dec_pkg::*;
(
  input  logic        addrLoad,
  input  logic        hostRd,
  input  logic        hostWr,
  output ctrlStrobe_t strobes
);
  logic accAny;

  always_comb begin
    accAny          = !addrLoad && (hostRd || hostWr);
    strobes.loadCnt = addrLoad;
    strobes.stepCnt = accAny;
    strobes.accWr   = accAny && hostWr;
    strobes.accRd   = accAny && hostRd && !hostWr;
  end
endmodule

// File: rtl/autoinc_dpath.sv
`timescale 1ns/1ps
module autoinc_dpath
  import autoinc_dec_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_UNITS = 4,
  parameter int DEPTH_W   = 9,
  parameter logic [NUM_UNITS*DEPTH_W-1:0] UNIT_DEPTHS = {9'd256, 9'd16, 9'd64, 9'd8}
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strobes,
  input  logic [ADDR_W-1:0]    loadValue,
  input  logic [DATA_W-1:0]    regRdata,
  input  logic [DATA_W-1:0]    bufRdata,
  output logic [DATA_W-1:0]    hostRdata,
  output logic [NUM_UNITS-1:0] regSel,
  output logic [OFF_W-1:0]     regOffset,
  output logic [NUM_BUFS-1:0]  bufSel,
  output logic [WORD_W-1:0]    bufWord,
  output logic                 intClr
);
  logic [ADDR_W-1:0]    addrCnt;
  logic [SPACE_W-1:0]   spaceNum;
  logic [UNIT_W-1:0]    unitNum;
  logic [OFF_W-1:0]     offNum;
  logic [NUM_UNITS-1:0] unitHit;
  logic [NUM_BUFS-1:0]  bufHit;
  logic                 accAny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               addrCnt <= '0;
    else if (strobes.loadCnt) addrCnt <= loadValue;
    else if (strobes.stepCnt) addrCnt <= addrCnt + 1'b1;
  end

  assign spaceNum = addrCnt[ADDR_W-1 -: SPACE_W];
  assign unitNum  = addrCnt[OFF_W +: UNIT_W];
  assign offNum   = addrCnt[OFF_W-1:0];
  assign accAny   = strobes.accRd || strobes.accWr;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    localparam logic [DEPTH_W-1:0] UnitDepth = UNIT_DEPTHS[u*DEPTH_W +: DEPTH_W];
    assign unitHit[u] = (spaceNum == '0) && (unitNum == UNIT_W'(u)) &&
                        (DEPTH_W'(offNum) < UnitDepth);
  end

  for (genvar b = 0; b < NUM_BUFS; b++) begin : gBuf
    assign bufHit[b] = (spaceNum == slotSpace(b));
  end

  assign regSel    = accAny ? unitHit : '0;
  assign bufSel    = accAny ? bufHit  : '0;
  assign regOffset = offNum;
  assign bufWord   = addrCnt[WORD_W-1:0];
  assign intClr    = accAny && (addrCnt == '0);

  always_comb begin
    hostRdata = '0;
    if (strobes.accRd) begin
      if (|unitHit)     hostRdata = regRdata;
      else if (|bufHit) hostRdata = bufRdata;
    end
  end

  assert_load_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadCnt |=> addrCnt == $past(loadValue));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.stepCnt && !strobes.loadCnt) |=> addrCnt == $past(addrCnt) + 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.stepCnt && !strobes.loadCnt) |=> $stable(addrCnt));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.stepCnt && !strobes.loadCnt && addrCnt == '1) |=> addrCnt == '0);
  assert_unit_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(regSel));
  assert_buf_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bufSel));
endmodule

// File: rtl/autoinc_addr_dec.sv
`timescale 1ns/1ps
module autoinc_addr_dec
  import autoinc_dec_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_UNITS = 4,
  parameter int DEPTH_W   = 9,
  parameter logic [NUM_UNITS*DEPTH_W-1:0] UNIT_DEPTHS = {9'd256, 9'd16, 9'd64, 9'd8}
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addrLoad,
  input  logic                 hostRd,
  input  logic                 hostWr,
  input  logic [ADDR_W-1:0]    hostWdata,
  output logic [DATA_W-1:0]    hostRdata,
  input  logic [DATA_W-1:0]    regRdata,
  input  logic [DATA_W-1:0]    bufRdata,
  output logic                 devRd,
  output logic                 devWr,
  output logic [NUM_UNITS-1:0] regSel,
  output logic [OFF_W-1:0]     regOffset,
  output logic [NUM_BUFS-1:0]  bufSel,
  output logic [WORD_W-1:0]    bufWord,
  output logic                 intClr
);
  ctrlStrobe_t strobes;

  autoinc_ctrl ctrl_i (
    .addrLoad (addrLoad),
    .hostRd   (hostRd),
    .hostWr   (hostWr),
    .strobes  (strobes)
  );

  autoinc_dpath #(
    .DATA_W      (DATA_W),
    .NUM_UNITS   (NUM_UNITS),
    .DEPTH_W     (DEPTH_W),
    .UNIT_DEPTHS (UNIT_DEPTHS)
  ) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .loadValue (hostWdata),
    .regRdata  (regRdata),
    .bufRdata  (bufRdata),
    .hostRdata (hostRdata),
    .regSel    (regSel),
    .regOffset (regOffset),
    .bufSel    (bufSel),
    .bufWord   (bufWord),
    .intClr    (intClr)
  );

  assign devRd = strobes.accRd;
  assign devWr = strobes.accWr;

  assert_load_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addrLoad |-> (!devRd && !devWr && regSel == '0 && bufSel == '0 && !intClr));
  assert_space_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((|regSel) && (|bufSel)));
  assert_clr_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    intClr |-> (regOffset == '0 && bufSel == '0 && (devRd || devWr)));
  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (regSel == '0 && bufSel == '0) |-> hostRdata == '0);
endmodule

// File: tb/autoinc_addr_dec_tb.sv
`timescale 1ns/1ps
module autoinc_addr_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addrLoad = 1'b0, hostRd = 1'b0, hostWr = 1'b0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic [15:0] regRdata = 16'h1234;
  logic [15:0] bufRdata = 16'hBEEF;
  logic        devRd, devWr, intClr;
  logic [3:0]  regSel;
  logic [7:0]  regOffset;
  logic [10:0] bufSel;
  logic [11:0] bufWord;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  autoinc_addr_dec dut_i (
    .clk(clk), .rst_n(rst_n), .addrLoad(addrLoad), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .regRdata(regRdata), .bufRdata(bufRdata),
    .devRd(devRd), .devWr(devWr), .regSel(regSel), .regOffset(regOffset),
    .bufSel(bufSel), .bufWord(bufWord), .intClr(intClr)
  );

  task automatic checkEq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive inputs just after a falling edge, then settle
  task automatic drive(input logic ld, input logic rd, input logic wr, input logic [15:0] wd);
    @(negedge clk);
    addrLoad = ld; hostRd = rd; hostWr = wr; hostWdata = wd;
    #1;
  endtask

  function automatic logic [3:0] expRegSel(input logic [15:0] a);
    int depthTab [4] = '{8, 64, 16, 256};
    int u;
    if (a[15:12] != 4'h0) return 4'h0;
    u = int'(a[11:8]);
    if (u >= 4) return 4'h0;
    if (int'(a[7:0]) < depthTab[u]) return 4'(1 << u);
    return 4'h0;
  endfunction

  function automatic logic [10:0] expBufSel(input logic [15:0] a);
    int s = int'(a[15:12]);
    if (s >= 1 && s <= 3) return 11'(1 << (s - 1));
    if (s >= 8) return 11'(1 << (s - 5));
    return 11'h0;
  endfunction

  // one access at expected address a; checks full decode
  task automatic accessAt(input string req, input logic [15:0] a, input logic rd, input logic wr);
    logic [15:0] expData;
    logic expRd, expWr;
    drive(1'b0, rd, wr, 16'h0);
    expWr = wr;
    expRd = rd && !wr;
    expData = 16'h0;
    if (expRd && expRegSel(a) != 0) expData = regRdata;
    else if (expRd && expBufSel(a) != 0) expData = bufRdata;
    checkEq(req, "devRd", 32'(devRd), 32'(expRd));
    checkEq(req, "devWr", 32'(devWr), 32'(expWr));
    checkEq(req, "regSel", 32'(regSel), 32'(expRegSel(a)));
    checkEq(req, "bufSel", 32'(bufSel), 32'(expBufSel(a)));
    checkEq(req, "intClr", 32'(intClr), 32'(a == 16'h0));
    checkEq(req, "hostRdata", 32'(hostRdata), 32'(expData));
    if (expRegSel(a) != 0) checkEq(req, "regOffset", 32'(regOffset), 32'(a[7:0]));
    if (expBufSel(a) != 0) checkEq(req, "bufWord", 32'(bufWord), 32'(a[11:0]));
  endtask

  task automatic loadAddr(input string req, input logic [15:0] a);
    drive(1'b1, 1'b0, 1'b0, a);
    checkEq(req, "load devRd", 32'(devRd), 32'h0);
    checkEq(req, "load regSel", 32'(regSel), 32'h0);
    checkEq(req, "load bufSel", 32'(bufSel), 32'h0);
    checkEq(req, "load intClr", 32'(intClr), 32'h0);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic t_reset();
    idle();
    checkEq("R9", "reset rdata", 32'(hostRdata), 32'h0);
    checkEq("R8", "reset intClr", 32'(intClr), 32'h0);
    checkEq("R4", "reset regSel", 32'(regSel), 32'h0);
    // counter resets to 0: first access clears interrupts, then steps to 1
    accessAt("R8", 16'h0000, 1'b1, 1'b0);
    accessAt("R2", 16'h0001, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_load_then_run();
    loadAddr("R1", 16'h0000);
    idle();
    idle();
    checkEq("R1", "no clear while idle", 32'(intClr), 32'h0);
    accessAt("R1", 16'h0000, 1'b1, 1'b0);
    accessAt("R2", 16'h0001, 1'b0, 1'b1);
    accessAt("R2", 16'h0002, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_reg_decode();
    loadAddr("R4", 16'h0105);
    accessAt("R4", 16'h0105, 1'b1, 1'b0);
    accessAt("R9", 16'h0106, 1'b0, 1'b1);
    loadAddr("R4", 16'h02A0);
    accessAt("R7", 16'h02A0, 1'b1, 1'b0);
    loadAddr("R4", 16'h030E);
    accessAt("R4", 16'h030E, 1'b1, 1'b0);
    loadAddr("R4", 16'h0207);
    accessAt("R4", 16'h0207, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_buf_decode();
    logic [3:0] spaces [6] = '{4'h1, 4'h2, 4'h3, 4'h8, 4'hC, 4'hF};
    for (int i = 0; i < 6; i++) begin
      logic [15:0] a = {spaces[i], 12'(12'h5A0 + i)};
      loadAddr("R5", a);
      accessAt("R5", a, 1'b1, 1'b0);
      accessAt("R5", a + 16'h1, 1'b0, 1'b1);
    end
    idle();
  endtask

  task automatic t_unmapped_space();
    loadAddr("R6", 16'h4123);
    accessAt("R6", 16'h4123, 1'b1, 1'b0);
    loadAddr("R6", 16'h7FFF);
    accessAt("R6", 16'h7FFF, 1'b1, 1'b0);
    accessAt("R6", 16'h8000, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_unit_bounds();
    loadAddr("R7", 16'h0007);
    accessAt("R7", 16'h0007, 1'b1, 1'b0);
    accessAt("R7", 16'h0008, 1'b1, 1'b0);
    loadAddr("R7", 16'h0400);
    accessAt("R7", 16'h0400, 1'b1, 1'b0);
    loadAddr("R7", 16'h03FF);
    accessAt("R7", 16'h03FF, 1'b1, 1'b0);
    accessAt("R7", 16'h0400, 1'b0, 1'b1);
    idle();
  endtask

  task automatic t_wrap();
    loadAddr("R3", 16'hFFFE);
    accessAt("R3", 16'hFFFE, 1'b1, 1'b0);
    accessAt("R3", 16'hFFFF, 1'b0, 1'b1);
    accessAt("R3", 16'h0000, 1'b1, 1'b0);
    accessAt("R8", 16'h0001, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_priority();
    drive(1'b1, 1'b1, 1'b0, 16'h0200);
    checkEq("R10", "load+rd devRd", 32'(devRd), 32'h0);
    checkEq("R10", "load+rd regSel", 32'(regSel), 32'h0);
    accessAt("R10", 16'h0200, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 16'h0);
    checkEq("R10", "rd+wr devWr", 32'(devWr), 32'h1);
    checkEq("R10", "rd+wr devRd", 32'(devRd), 32'h0);
    checkEq("R10", "rd+wr rdata", 32'(hostRdata), 32'h0);
    accessAt("R10", 16'h0202, 1'b1, 1'b0);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_then_run();
    t_reg_decode();
    t_buf_decode();
    t_unmapped_space();
    t_unit_bounds();
    t_wrap();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule